// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block sits in the path of a 36-bit data word that is split into four 9-bit lanes. In each lane the top bit carries parity for the eight bits beneath it. The block can rewrite those parity bits as the word passes through, and it checks the word that leaves it. It raises one error flag when a lane that is in scope has the wrong number of ones.

Configuration arrives as static inputs. They choose odd or even sense, turn generation on or off, and pick whether every lane is checked or only the lanes that the word-size code marks as in use. They also pick whether the flag follows the data combinationally or comes from a register clocked by the port clock. Generation happens first and checking second, so a lane whose parity bit the block has just produced can never be flagged.

Top module: `byte_parity_unit`

## Requirements
- R1: Lane k occupies bits 9k+8 down to 9k of the word; bit 9k+8 is the parity bit for bits 9k+7 to 9k.
- R2: With par_odd=0 (even sense), a lane is in error when its nine bits hold an odd number of ones.
- R3: With par_odd=1 (odd sense), a lane is in error when its nine bits hold an even number of ones.
- R4: With gen_en=0, data_o equals data_i bit for bit.
- R5: With gen_en=1, each lane's parity bit on data_o is the XOR of its eight low bits (even sense) or its inverse (odd sense), and all other bits equal data_i.
- R6: Checking is applied to the word after generation, so gen_en=1 never produces an error.
- R7: With chk_by_size=0, an error in any of the four lanes is reported, whatever the value of word_size.
- R8: With chk_by_size=1, word_size 2'b00 checks all four lanes, 2'b01 checks lanes 0 and 1 only, and 2'b10 or 2'b11 checks lane 0 only.
- R9: With flag_reg=0, par_err reflects the word presently on data_i in the same cycle.
- R10: With flag_reg=1, par_err shows the error state of the word that was present at the most recent rising clock edge, and holds between edges.
- R11: rst_n is active low and asynchronous on assertion; while it is low, and for two clock edges after it rises, the registered flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_odd | input | 1 | 1 selects odd sense, 0 even |
| gen_en | input | 1 | 1 rewrites each lane's parity bit |
| chk_by_size | input | 1 | 1 limits checking to the lanes word_size selects |
| flag_reg | input | 1 | 1 selects the registered error flag |
| word_size | input | 2 | 00 full word, 01 half word, 1x single byte |
| data_i | input | 36 | Incoming word, four 9-bit lanes |
| data_o | output | 36 | Outgoing word, parity bits possibly rewritten |
| par_err | output | 1 | Parity error flag |

## Verification
The hardest situation to set up is the registered flag. It must reflect the previous word and not the current one, and reset and the release synchronizer both delay it. The stimulus therefore alternates good and bad words from one cycle to the next while flag_reg is 1, so the one-cycle lag shows up as a mismatch whenever it is wrong. It also places a corrupted lane outside the selected word size while the scope control toggles, so a lane that leaks into the check is caught.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned LANE_BITS = DATA_BITS + 1;

  typedef enum logic [1:0] {
    WS_FULL = 2'b00,
    WS_HALF = 2'b01,
    WS_ONE  = 2'b10,
    WS_ONE2 = 2'b11
  } wsize_e;
endpackage

// File: rtl/bpu_lane.sv
module bpu_lane
  import bpu_pkg::*;
(
  input  logic [LANE_BITS-1:0] lane_i,
  input  logic                 odd_i,
  input  logic                 gen_i,
  output logic [LANE_BITS-1:0] lane_o,
  output logic                 bad_o
);
  logic fresh_bit;

  always_comb begin
    // parity bit that makes the lane total match the selected sense
    fresh_bit = (^lane_i[DATA_BITS-1:0]) ^ odd_i;
    lane_o    = lane_i;
    if (gen_i) begin
      lane_o[DATA_BITS] = fresh_bit;
    end
    // check after generation
    bad_o = (^lane_o) ^ odd_i;
  end
endmodule

// File: rtl/bpu_scope_mask.sv
module bpu_scope_mask
  import bpu_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             by_size_i,
  input  logic [1:0]       wsize_i,
  output logic [LANES-1:0] mask_o
);
  localparam int unsigned HALF = (LANES > 1) ? LANES / 2 : 1;

  always_comb begin
    mask_o = '1;
    if (by_size_i) begin
      unique case (wsize_e'(wsize_i))
        WS_FULL: mask_o = '1;
        WS_HALF: mask_o = LANES'((1 << HALF) - 1);
        default: mask_o = LANES'(1);
      endcase
    end
  end
endmodule

// File: rtl/bpu_flag_stage.sv
module bpu_flag_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_mode_i,
  input  logic err_i,
  output logic err_o
);
  logic rst_meta_q;
  logic rst_sync_n;
  logic flag_d;
  logic flag_q;
  logic flag_en;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    flag_en = 1'b1;
    flag_d  = err_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign err_o = reg_mode_i ? flag_q : err_i;

  // R10
  reg_flag_follows_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (flag_q == $past(err_i)));

  // R11
  reset_flag_clear_chk: assert property (@(posedge clk)
    !rst_sync_n |-> !flag_q);

  // R9
  flow_mode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !reg_mode_i |-> (err_o == err_i));
endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
  import bpu_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned WORD_W = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_odd,
  input  logic              gen_en,
  input  logic              chk_by_size,
  input  logic              flag_reg,
  input  logic [1:0]        word_size,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              par_err
);
  logic [LANES-1:0] lane_bad;
  logic [LANES-1:0] lane_mask;
  logic             err_now;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bpu_lane u_lane (
      .lane_i (data_i[k*LANE_BITS +: LANE_BITS]),
      .odd_i  (par_odd),
      .gen_i  (gen_en),
      .lane_o (data_o[k*LANE_BITS +: LANE_BITS]),
      .bad_o  (lane_bad[k])
    );

    // R6
    gen_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_en |-> !lane_bad[k]);

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> (data_o[k*LANE_BITS +: LANE_BITS] == data_i[k*LANE_BITS +: LANE_BITS]));

    // R5
    low_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_o[k*LANE_BITS +: DATA_BITS] == data_i[k*LANE_BITS +: DATA_BITS]);
  end

  bpu_scope_mask #(.LANES(LANES)) u_mask (
    .by_size_i (chk_by_size),
    .wsize_i   (word_size),
    .mask_o    (lane_mask)
  );

  // R8
  lane0_in_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_mask[0]);

  // R7
  whole_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_by_size |-> (lane_mask == {LANES{1'b1}}));

  assign err_now = |(lane_bad & lane_mask);

  bpu_flag_stage u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_mode_i (flag_reg),
    .err_i      (err_now),
    .err_o      (par_err)
  );
endmodule

// File: tb/byte_parity_unit_tb_top.sv
`timescale 1ns/1ps
module byte_parity_unit_tb_top;
  localparam int LANES = 4;
  localparam int W = LANES * 9;

  logic clk = 1'b0;
  logic rst_n;
  logic par_odd, gen_en, chk_by_size, flag_reg;
  logic [1:0] word_size;
  logic [W-1:0] data_i;
  logic [W-1:0] data_o;
  logic par_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] dout;
    logic         err;
    string        tag;
  } exp_t;
  exp_t sb_q[$];
  event sample_ev;
  logic prev_err;

  always #2.5 clk = ~clk;

  byte_parity_unit dut_i (
    .clk(clk), .rst_n(rst_n), .par_odd(par_odd), .gen_en(gen_en),
    .chk_by_size(chk_by_size), .flag_reg(flag_reg), .word_size(word_size),
    .data_i(data_i), .data_o(data_o), .par_err(par_err)
  );

  function automatic logic [W-1:0] model_out(logic [W-1:0] d, logic odd, logic gen);
    logic [W-1:0] r = d;
    for (int k = 0; k < LANES; k++)
      if (gen) r[k*9+8] = (^d[k*9 +: 8]) ^ odd;
    return r;
  endfunction

  function automatic logic model_err(logic [W-1:0] o, logic odd, logic bysz, logic [1:0] ws);
    logic e = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      logic in_scope;
      in_scope = !bysz || ws == 2'b00 || (ws == 2'b01 && k < 2) || k == 0;
      if (in_scope && ((^o[k*9 +: 9]) ^ odd)) e = 1'b1;
    end
    return e;
  endfunction

  // driver: applies one word at the falling edge and queues the expectation
  task automatic apply(logic [W-1:0] d, logic odd, logic gen, logic bysz,
                       logic freg, logic [1:0] ws, bit in_rst, string tag);
    exp_t it;
    logic now_err;
    @(negedge clk);
    data_i = d; par_odd = odd; gen_en = gen; chk_by_size = bysz;
    flag_reg = freg; word_size = ws;
    it.dout = model_out(d, odd, gen);
    now_err = model_err(it.dout, odd, bysz, ws);
    it.err  = freg ? prev_err : now_err;
    it.tag  = tag;
    prev_err = in_rst ? 1'b0 : now_err;
    sb_q.push_back(it);
    -> sample_ev;
  endtask

  // monitor: compares after the inputs settle, away from the clock edge
  always @(sample_ev) begin
    exp_t it;
    #1;
    it = sb_q.pop_front();
    n_chk++;
    if (data_o !== it.dout) begin
      n_fail++;
      $display("FAIL %s data_o actual=%h expected=%h", it.tag, data_o, it.dout);
    end
    n_chk++;
    if (par_err !== it.err) begin
      n_fail++;
      $display("FAIL %s par_err actual=%b expected=%b", it.tag, par_err, it.err);
    end
  end

  // lane k with low byte v and its parity bit p
  function automatic logic [8:0] ln(logic [7:0] v, logic p);
    return {p, v};
  endfunction

  initial begin
    logic [W-1:0] good_e, bad3, bad1, bad0, gw;
    prev_err = 1'b0;
    rst_n = 1'b0;
    data_i = '0; par_odd = 0; gen_en = 0; chk_by_size = 0; flag_reg = 0; word_size = 0;
    // even-correct word: each lane has an even count of ones
    good_e = {ln(8'h0F,0), ln(8'h01,1), ln(8'hFF,0), ln(8'h80,1)};
    bad3   = good_e ^ (W'(1) << 27);
    bad1   = good_e ^ (W'(1) << 9);
    bad0   = good_e ^ W'(1);

    // R11: registered flag held clear during reset despite a bad word
    apply(bad0, 0, 0, 0, 1, 2'b00, 1, "R11 reset");
    apply(bad3, 0, 0, 0, 1, 2'b00, 1, "R11 reset");
    @(negedge clk); rst_n = 1'b1;
    apply(bad0, 0, 0, 0, 1, 2'b00, 1, "R11 sync");
    apply('0, 0, 0, 0, 0, 2'b00, 0, "R11 idle");
    apply('0, 0, 0, 0, 0, 2'b00, 0, "R11 idle");

    // R1 R2 R4: even sense, flow-through
    apply(good_e, 0, 0, 0, 0, 2'b00, 0, "R2 good even");
    apply(bad3,   0, 0, 0, 0, 2'b00, 0, "R1 R2 lane3 bad");
    apply(bad1,   0, 0, 0, 0, 2'b00, 0, "R1 R4 lane1 bad");
    // R3: the even-correct word fails every lane in odd sense
    apply(good_e, 1, 0, 0, 0, 2'b00, 0, "R3 odd sense");
    apply(good_e ^ {4{9'h100}}, 1, 0, 0, 0, 2'b00, 0, "R3 odd good");
    // R7: whole-word scope ignores word_size
    apply(bad3, 0, 0, 0, 0, 2'b10, 0, "R7 whole byte");
    apply(bad3, 0, 0, 0, 0, 2'b01, 0, "R7 whole half");
    // R8: width-dependent scope
    apply(bad3, 0, 0, 1, 0, 2'b00, 0, "R8 full");
    apply(bad3, 0, 0, 1, 0, 2'b01, 0, "R8 half excl3");
    apply(bad1, 0, 0, 1, 0, 2'b01, 0, "R8 half incl1");
    apply(bad1, 0, 0, 1, 0, 2'b10, 0, "R8 one excl1");
    apply(bad1, 0, 0, 1, 0, 2'b11, 0, "R8 one excl1 11");
    apply(bad0, 0, 0, 1, 0, 2'b11, 0, "R8 one incl0");
    // R5 R6: generation overwrites parity, never flags
    gw = {ln(8'h3C,1), ln(8'h07,0), ln(8'hA5,1), ln(8'h01,0)};
    apply(gw, 0, 1, 0, 0, 2'b00, 0, "R5 R6 gen even");
    apply(gw, 1, 1, 0, 0, 2'b00, 0, "R5 R6 gen odd");
    apply(bad3, 1, 1, 1, 0, 2'b01, 0, "R5 R6 gen scoped");
    // R9 R10: alternate good and bad in flow then registered mode
    for (int i = 0; i < 6; i++)
      apply(i[0] ? bad0 : good_e, 0, 0, 0, 0, 2'b00, 0, "R9 flow alt");
    for (int i = 0; i < 8; i++)
      apply(i[0] ? bad1 : good_e, 0, 0, 0, 1, 2'b00, 0, "R10 reg alt");
    apply(bad3, 0, 0, 1, 1, 2'b01, 0, "R10 reg scoped");
    apply(bad3, 0, 0, 0, 1, 2'b01, 0, "R10 reg whole");
    apply(good_e, 0, 0, 0, 1, 2'b00, 0, "R10 reg clear");
    apply(good_e, 0, 0, 0, 0, 2'b00, 0, "R9 back to flow");
    // R11: asynchronous assertion mid-run
    apply(bad0, 0, 0, 0, 1, 2'b00, 0, "R11 before");
    @(negedge clk); rst_n = 1'b0; prev_err = 1'b0;
    apply(bad0, 0, 0, 0, 1, 2'b00, 1, "R11 async");
    @(negedge clk);
    #2;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule